// File: doc/BRIEF.md
# Page Table Walker

This block turns a virtual address into a physical address. It reads a chain of translation tables held in memory. Each read depends on the one before it: the entry it returns gives the frame where the next table starts. A requester hands over a virtual address and a mode bit. The walker then issues reads one at a time on a simple request/response memory port, starting from a root table base supplied on an input. It returns either the physical address or a fault, and holds that response until the requester acknowledges it.

There are two layouts. The narrow layout has two levels with 4-byte entries and 1024 entries per table, and it decodes virtual address bits 31:12. The wide layout has four levels with 8-byte entries and 512 entries per table, and it decodes virtual address bits 47:12. In both layouts the low 12 address bits are a byte offset inside a 4 KiB page and are copied unchanged into the result. Each entry holds a valid flag in bit 0. The frame address is the entry with bits 11:0 cleared.

Top module: `ptw_walker`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: A request is taken only on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the response has been acknowledged. While it is 0, `req_valid`, `req_vaddr`, `req_mode` and `root_base` have no effect on the memory addresses issued or on the result.
- R3: With `req_mode`=0 (narrow), the first entry address is `{32'b0, root_base[31:12], 12'b0} + 4*vaddr[31:22]`. The second entry address is `frame + 4*vaddr[21:12]`. Only `mem_rsp_data[31:0]` is used as the entry. Bits 63:32 of the virtual address, of `root_base` and of the read data are ignored, and `rsp_paddr[63:32]` is 0.
- R4: With `req_mode`=1 (wide), four levels are read. Level L (0 to 3) has entry address `base + 8*vaddr[47-9L : 39-9L]`. Level 0 uses `root_base` with bits 11:0 cleared as its base. Each later level uses the frame of the entry read before it.
- R5: An entry is valid when bit 0 is 1. Its frame is the entry with bits 11:0 cleared. After a valid last-level entry, `rsp_paddr` equals that frame OR `vaddr[11:0]`.
- R6: An entry with bit 0 clear at level L ends the walk at once, with no further read. The response then has `rsp_fault`=1, `rsp_level`=L and `rsp_paddr`=0.
- R7: At most one memory read is outstanding. `mem_req_valid` is asserted only while no read is waiting for data. It stays 1, with `mem_req_addr` unchanged, until `mem_req_ready` is sampled 1. `mem_rsp_valid` has no effect while no read is outstanding.
- R8: `rsp_valid` rises on the edge that takes the last needed read response. `rsp_valid`, `rsp_paddr`, `rsp_fault` and `rsp_level` stay constant until an edge with `rsp_ack`=1. After that edge `rsp_valid` is 0 and `req_ready` is 1.
- R9: A successful response has `rsp_fault`=0 and `rsp_level` equal to the last level: 1 in narrow mode, 3 in wide mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| root_base | input | 64 | Base address of the top-level table, sampled when a request is taken |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker is idle and will take a request |
| req_mode | input | 1 | 0 = narrow two-level layout, 1 = wide four-level layout |
| req_vaddr | input | 64 | Virtual address to translate |
| rsp_valid | output | 1 | Result available |
| rsp_ack | input | 1 | Requester takes the result |
| rsp_paddr | output | 64 | Physical address, or 0 on a fault |
| rsp_fault | output | 1 | An invalid entry was found |
| rsp_level | output | 2 | Level of the last entry read |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 64 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Read data, entry in the low bytes |

## Verification
The hardest conditions to reach are faults at the middle levels of the wide walk. Each one needs every level above it to hold a valid entry while the slot it indexes is empty. The bench builds one complete wide mapping, then repeats the request with the virtual address changed in exactly one index field, so that the walk leaves the mapped path at a chosen level and lands on an unwritten slot. Narrow entries are placed next to each other, so that the upper half of each 8-byte read holds garbage. Out-of-place memory responses, requests made while busy and random back-pressure are mixed in all the time, and a cycle-level model predicts every handshake.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    S_IDLE,
    S_FETCH,
    S_WAIT,
    S_DONE
  } walk_state_t;

  localparam logic MODE_NARROW = 1'b0;
  localparam logic MODE_WIDE   = 1'b1;
endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
  parameter int ADDR_W  = 64,
  parameter int OFF_W   = 12,
  parameter int IDX_W32 = 10,
  parameter int IDX_W64 = 9,
  parameter int LVL_W32 = 2,
  parameter int LVL_W64 = 4,
  parameter int LVL_CW  = 2,
  parameter int ESH32   = 2,
  parameter int ESH64   = 3,
  parameter int NARROW_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [LVL_CW-1:0] level,
  input  logic              mode64,
  output logic [ADDR_W-1:0] entry_addr
);
  localparam logic [ADDR_W-1:0] MASK32  = {{(ADDR_W-IDX_W32){1'b0}}, {IDX_W32{1'b1}}};
  localparam logic [ADDR_W-1:0] MASK64  = {{(ADDR_W-IDX_W64){1'b0}}, {IDX_W64{1'b1}}};
  localparam logic [ADDR_W-1:0] PAGE_M  = {{(ADDR_W-OFF_W){1'b1}}, {OFF_W{1'b0}}};
  localparam logic [ADDR_W-1:0] LOW_M   = {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  int                shamt;
  logic [ADDR_W-1:0] shifted;
  logic [ADDR_W-1:0] idx_ext;
  logic [ADDR_W-1:0] base_eff;

  always_comb begin
    if (mode64) begin
      shamt    = OFF_W + (LVL_W64 - 1 - int'(level)) * IDX_W64;
      shifted  = vaddr >> shamt;
      idx_ext  = (shifted & MASK64) << ESH64;
      base_eff = base & PAGE_M;
    end else begin
      shamt    = OFF_W + (LVL_W32 - 1 - int'(level)) * IDX_W32;
      shifted  = vaddr >> shamt;
      idx_ext  = (shifted & MASK32) << ESH32;
      base_eff = base & PAGE_M & LOW_M;
    end
    entry_addr = base_eff + idx_ext;
  end
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
  parameter int ADDR_W   = 64,
  parameter int OFF_W    = 12,
  parameter int NARROW_W = 32
) (
  input  logic [ADDR_W-1:0] raw,
  input  logic              mode64,
  output logic              valid,
  output logic [ADDR_W-1:0] frame
);
  localparam logic [ADDR_W-1:0] LOW_M  = {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [ADDR_W-1:0] PAGE_M = {{(ADDR_W-OFF_W){1'b1}}, {OFF_W{1'b0}}};

  logic [ADDR_W-1:0] entry;

  always_comb begin
    entry = mode64 ? raw : (raw & LOW_M);
    valid = entry[0];
    frame = entry & PAGE_M;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int OFF_W    = 12,
  parameter int IDX_W32  = 10,
  parameter int IDX_W64  = 9,
  parameter int LVL_W32  = 2,
  parameter int LVL_W64  = 4,
  parameter int ENT_B32  = 4,
  parameter int ENT_B64  = 8,
  parameter int NARROW_W = 32,
  localparam int LVL_CW  = $clog2(LVL_W64),
  localparam int ESH32   = $clog2(ENT_B32),
  localparam int ESH64   = $clog2(ENT_B64)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] root_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_mode,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              rsp_valid,
  input  logic              rsp_ack,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic [LVL_CW-1:0] rsp_level,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data
);
  localparam logic [ADDR_W-1:0] OFF_M = {{(ADDR_W-OFF_W){1'b0}}, {OFF_W{1'b1}}};

  walk_state_t       state_q;
  logic [ADDR_W-1:0] vaddr_q;
  logic              m64_q;
  logic [LVL_CW-1:0] level_q;
  logic [ADDR_W-1:0] addr_q;

  logic [ADDR_W-1:0] gen_base, gen_va, gen_addr, ent_frame;
  logic [LVL_CW-1:0] gen_level;
  logic              gen_m64, ent_valid, last_lvl;

  // Address generator inputs: root at request time, previous frame later
  always_comb begin
    if (state_q == S_IDLE) begin
      gen_base  = root_base;
      gen_va    = req_vaddr;
      gen_level = '0;
      gen_m64   = req_mode;
    end else begin
      gen_base  = ent_frame;
      gen_va    = vaddr_q;
      gen_level = level_q + 1'b1;
      gen_m64   = m64_q;
    end
    last_lvl = (m64_q == MODE_WIDE) ? (level_q == LVL_CW'(LVL_W64 - 1))
                                    : (level_q == LVL_CW'(LVL_W32 - 1));
  end

  ptw_index_sel #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W32(IDX_W32), .IDX_W64(IDX_W64),
    .LVL_W32(LVL_W32), .LVL_W64(LVL_W64), .LVL_CW(LVL_CW),
    .ESH32(ESH32), .ESH64(ESH64), .NARROW_W(NARROW_W)
  ) u_index (
    .base      (gen_base),
    .vaddr     (gen_va),
    .level     (gen_level),
    .mode64    (gen_m64),
    .entry_addr(gen_addr)
  );

  ptw_entry_decode #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .NARROW_W(NARROW_W)
  ) u_decode (
    .raw   (mem_rsp_data),
    .mode64(m64_q),
    .valid (ent_valid),
    .frame (ent_frame)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      vaddr_q   <= '0;
      m64_q     <= MODE_NARROW;
      level_q   <= '0;
      addr_q    <= '0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      rsp_level <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            vaddr_q <= req_vaddr;
            m64_q   <= req_mode;
            level_q <= '0;
            addr_q  <= gen_addr;
            state_q <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (mem_req_ready) state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            if (!ent_valid) begin
              rsp_fault <= 1'b1;
              rsp_level <= level_q;
              rsp_paddr <= '0;
              state_q   <= S_DONE;
            end else if (last_lvl) begin
              rsp_fault <= 1'b0;
              rsp_level <= level_q;
              rsp_paddr <= ent_frame | (vaddr_q & OFF_M);
              state_q   <= S_DONE;
            end else begin
              level_q <= level_q + 1'b1;
              addr_q  <= gen_addr;
              state_q <= S_FETCH;
            end
          end
        end
        S_DONE: begin
          if (rsp_ack) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == S_IDLE);
  assign mem_req_valid = (state_q == S_FETCH);
  assign rsp_valid     = (state_q == S_DONE);
  assign mem_req_addr  = addr_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int ADDR_W  = 64,
  parameter int OFF_W   = 12,
  parameter int LVL_CW  = 2,
  parameter int LVL_W32 = 2,
  parameter int LVL_W64 = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_mode,
  input logic [OFF_W-1:0]  req_vaddr_lo,
  input logic              rsp_valid,
  input logic              rsp_ack,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              rsp_fault,
  input logic [LVL_CW-1:0] rsp_level,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid
);
  logic             out_q;
  logic             m64_q;
  logic [OFF_W-1:0] va_lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= 1'b0;
      m64_q   <= 1'b0;
      va_lo_q <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) out_q <= 1'b1;
      else if (mem_rsp_valid)             out_q <= 1'b0;
      if (req_valid && req_ready) begin
        m64_q   <= req_mode;
        va_lo_q <= req_vaddr_lo;
      end
    end
  end

  // R7
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_q && mem_req_valid));

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ack |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)
                              && $stable(rsp_level));

  // R8
  ack_return_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_ack |=> req_ready && !rsp_valid);

  // R2
  busy_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req_valid && !rsp_valid);

  // R6
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_paddr == '0);

  // R5
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_fault |-> rsp_paddr[OFF_W-1:0] == va_lo_q);

  // R9
  final_level_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_fault |->
      rsp_level == (m64_q ? LVL_CW'(LVL_W64 - 1) : LVL_CW'(LVL_W32 - 1)));

  // R3
  narrow_addr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !m64_q |-> mem_req_addr[ADDR_W-1:32] == '0 && mem_req_addr[1:0] == 2'b00);

  // R3
  narrow_result_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !m64_q |-> rsp_paddr[ADDR_W-1:32] == '0);

  // R4
  wide_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && m64_q |-> mem_req_addr[2:0] == 3'b000);
endmodule

bind ptw_walker ptw_walker_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LVL_CW(LVL_CW), .LVL_W32(LVL_W32), .LVL_W64(LVL_W64)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_mode     (req_mode),
  .req_vaddr_lo (req_vaddr[OFF_W-1:0]),
  .rsp_valid    (rsp_valid),
  .rsp_ack      (rsp_ack),
  .rsp_paddr    (rsp_paddr),
  .rsp_fault    (rsp_fault),
  .rsp_level    (rsp_level),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] root_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_mode = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ack = 1'b0;
  logic [63:0] rsp_paddr;
  logic        rsp_fault;
  logic [1:0]  rsp_level;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  always #4 clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst(rst), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_level(rsp_level), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- memory image ----------------
  logic [7:0] mem [logic [63:0]];

  function automatic logic [63:0] rd64(logic [63:0] a);
    logic [63:0] r;
    for (int b = 0; b < 8; b++)
      r[8*b +: 8] = mem.exists(a + 64'(b)) ? mem[a + 64'(b)] : 8'h00;
    return r;
  endfunction

  task automatic wr(logic [63:0] a, logic [63:0] v, int nbytes);
    for (int b = 0; b < nbytes; b++) mem[a + 64'(b)] = v[8*b +: 8];
  endtask

  // ---------------- reference model ----------------
  logic [63:0] m_addrs [$];
  int          m_idx;
  bit          m_busy, m_out, m_rsp, m_mode;
  logic [63:0] m_paddr;
  bit          m_fault;
  int          m_level;

  task automatic predict(logic [63:0] va, bit wide, logic [63:0] root);
    logic [63:0] base, a, e;
    int nlev, idx;
    m_addrs.delete();
    m_fault = 0;
    m_paddr = 0;
    nlev = wide ? 4 : 2;
    base = wide ? (root & ~64'hFFF) : (root & 64'h0000_0000_FFFF_F000);
    for (int lv = 0; lv < nlev; lv++) begin
      if (wide) begin
        idx = int'((va >> (39 - 9*lv)) & 64'h1FF);
        a = base + 64'(idx) * 8;
        e = rd64(a);
      end else begin
        idx = int'((va >> (22 - 10*lv)) & 64'h3FF);
        a = base + 64'(idx) * 4;
        e = rd64(a) & 64'hFFFF_FFFF;
      end
      m_addrs.push_back(a);
      m_level = lv;
      if (!e[0]) begin
        m_fault = 1;
        return;
      end
      base = e & ~64'hFFF;
    end
    m_paddr = base | (va & 64'hFFF);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_out = 0; m_rsp = 0; m_idx = 0;
    end else if (!m_busy) begin
      if (req_valid) begin
        predict(req_vaddr, req_mode, root_base);
        m_mode = req_mode;
        m_busy = 1; m_idx = 0; m_out = 0; m_rsp = 0;
      end
    end else if (m_rsp) begin
      if (rsp_ack) begin m_busy = 0; m_rsp = 0; end
    end else if (!m_out) begin
      if (mem_req_ready) m_out = 1;
    end else if (mem_rsp_valid) begin
      m_out = 0;
      m_idx++;
      if (m_idx == m_addrs.size()) m_rsp = 1;
    end
  end

  // per-clock comparison
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && !finished) begin
        bit fetch;
        fetch = m_busy && !m_rsp && !m_out;
        check(req_ready == !m_busy, "R2 req_ready", 64'(req_ready), 64'(!m_busy));
        check(rsp_valid == m_rsp, "R8 rsp_valid", 64'(rsp_valid), 64'(m_rsp));
        check(mem_req_valid == fetch, "R7 mem_req_valid", 64'(mem_req_valid), 64'(fetch));
        if (fetch) begin
          if (m_mode) check(mem_req_addr == m_addrs[m_idx], "R4 entry address", mem_req_addr, m_addrs[m_idx]);
          else        check(mem_req_addr == m_addrs[m_idx], "R3 entry address", mem_req_addr, m_addrs[m_idx]);
        end
        if (m_rsp) begin
          check(rsp_fault == m_fault, m_fault ? "R6 fault flag" : "R9 fault flag",
                64'(rsp_fault), 64'(m_fault));
          check(int'(rsp_level) == m_level, m_fault ? "R6 fault level" : "R9 final level",
                64'(rsp_level), 64'(m_level));
          check(rsp_paddr == m_paddr, m_fault ? "R6 zero address" : "R5 physical address",
                rsp_paddr, m_paddr);
        end
      end
    end
  end

  // ---------------- memory responder and acknowledger ----------------
  initial begin
    bit pend = 0;
    int lat = 0;
    logic [63:0] raddr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      rsp_ack = ($urandom_range(0, 1) == 1);
      if (rst) begin
        pend = 0;
        mem_req_ready = 1'b0;
      end else begin
        if (pend) begin
          if (lat == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = rd64(raddr);
            pend = 0;
          end else lat--;
        end else begin
          mem_req_ready = ($urandom_range(0, 2) != 0);
          if (mem_req_valid && mem_req_ready) begin
            pend  = 1;
            raddr = mem_req_addr;
            lat   = $urandom_range(0, 3);
          end else if (!mem_req_valid && $urandom_range(0, 4) == 0) begin
            // stray response with no read outstanding (R7)
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = {$urandom, $urandom} | 64'h1;
          end
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_req(logic [63:0] va, bit wide, logic [63:0] root);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_mode = wide; root_base = root;
    do @(negedge clk); while (!m_busy);
    // busy-time noise that must be ignored (R2)
    req_vaddr = ~va; req_mode = ~wide; root_base = ~root;
    @(negedge clk);
    req_valid = 1'b0;
    while (m_busy) @(negedge clk);
  endtask

  localparam logic [63:0] W_ROOT = 64'h0000_0000_0001_0000;
  localparam logic [63:0] W_LEAF = 64'h0000_0ABC_DEF0_1000;

  task automatic map_wide(logic [63:0] va);
    logic [63:0] tbl [4];
    tbl[0] = W_ROOT;
    tbl[1] = 64'h21000;
    tbl[2] = 64'h22000;
    tbl[3] = 64'h23000;
    for (int lv = 0; lv < 4; lv++) begin
      logic [63:0] slot, val;
      slot = tbl[lv] + ((va >> (39 - 9*lv)) & 64'h1FF) * 8;
      val  = (lv == 3) ? (W_LEAF | 64'h3) : (tbl[lv+1] | 64'h1);
      wr(slot, val, 8);
    end
  endtask

  logic [63:0] va_w;

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 req_ready in reset", 64'(req_ready), 64'd1);
    check(rsp_valid == 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1 && !mem_req_valid && !rsp_valid, "R1 after reset",
          {61'd0, req_ready, mem_req_valid, rsp_valid}, 64'd4);

    // narrow tables: neighbouring entries fill the upper half of each 8-byte read (R3)
    wr(64'h1120, 64'h0000_3001, 4);
    wr(64'h1124, 64'h1234_5000, 4);
    wr(64'h3D14, 64'h0ABC_D003, 4);
    wr(64'h3D18, 64'hFFFF_FFFE, 4);
    do_req(64'hFFFF_FFFF_1234_5678, 1'b0, 64'hDEAD_0000_0000_1ABC); // R3 R5 R9 success
    do_req(64'h0000_0000_1234_6ABC, 1'b0, 64'h0000_0000_0000_1000); // R6 fault at level 1
    do_req(64'h0000_0000_1240_0000, 1'b0, 64'h0000_0000_0000_1000); // R6 fault at level 0

    // wide mapping (R4)
    va_w = 64'h0000_5A5A_5A5A_5123;
    map_wide(va_w);
    do_req(va_w, 1'b1, W_ROOT | 64'h777);                 // R4 R5 R9 success
    do_req(va_w ^ (64'd1 << 12), 1'b1, W_ROOT);            // R6 level 3
    do_req(va_w ^ (64'd1 << 21), 1'b1, W_ROOT);            // R6 level 2
    do_req(va_w ^ (64'd1 << 30), 1'b1, W_ROOT);            // R6 level 1
    do_req(va_w ^ (64'd1 << 39), 1'b1, W_ROOT);            // R6 level 0

    // mixed traffic with random offsets and occasional off-path index
    for (int i = 0; i < 24; i++) begin
      logic [63:0] va;
      bit wide;
      wide = ($urandom_range(0, 1) == 1);
      va = wide ? va_w : 64'h0000_0000_1234_5000;
      va = (va & ~64'hFFF) | 64'($urandom_range(0, 4095));
      if ($urandom_range(0, 3) == 0) va = va ^ (64'd1 << (12 + $urandom_range(0, 35)));
      do_req(va, wide, wide ? W_ROOT : 64'h1000);
    end

    repeat (4) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule